// File: doc/BRIEF.md
# SPI Serial Memory Slave Front-End

This block is the serial edge of a memory device that acts as an SPI slave. It takes the serial clock, chip select, data input and a pause (hold) input from the bus. It assembles the incoming bits into bytes and hands each finished byte to the command layer behind it. In the other direction it takes bytes from that layer and shifts them out, most significant bit first. The output is driven only while the device is selected and not paused. Instruction decoding, the array, the status register and write timing belong to the command layer and are not part of this block.

All bus pins are brought into the local clock domain through a synchronizer bank, and clock edges are detected there. The serial clock must therefore be several times slower than the local clock. Both supported clock modes (clock idling low, and clock idling high) use the same edge rules: data is sampled on the rising edge and changes on the falling edge. The block needs no mode setting.

After reset the block stays silent until it sees a falling edge of chip select. A chip select that is already low when reset ends does not count as that edge.

Top module: `spi_mem_front`

## Requirements
- R1: Each rising serial clock edge, while the block is selected and not paused, samples one input bit. Bits arrive most significant first. After the 8th bit the whole byte appears on `rx_data_o`, and `rx_valid_o` is high for exactly one local clock cycle.
- R2: The output bit changes only on falling serial clock edges, most significant bit first. The first bit of a byte after a byte boundary is driven on the first falling edge that follows that boundary. The byte loaded at that edge is the one the command layer supplied.
- R3: Transfers behave the same whether the serial clock idles low or idles high between transfers.
- R4: While chip select is high, or while the block is in reset, `miso_oe_o` is low.
- R5: From reset until the first high-to-low transition of chip select, no input byte is reported and `miso_oe_o` stays low. This holds even if chip select was already low when reset ended.
- R6: Raising chip select discards any partly received byte. The next selection starts on a fresh byte boundary.
- R7: While selected with `hold_n_i` low, `miso_oe_o` is low and serial clock and data activity are ignored. The bit position and both shift registers keep their state, so the byte continues correctly after release.
- R8: `tx_req_o` pulses together with each `rx_valid_o`. A byte offered with `tx_valid_i` while selected is stored. If several bytes are offered before a load, the latest one is shifted out.
- R9: If no byte has been supplied by the time a new output byte starts, the block shifts out all ones (0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the bus master |
| cs_n_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data input |
| hold_n_i | input | 1 | Active-low pause of the current transfer |
| miso_o | output | 1 | Serial data output value |
| miso_oe_o | output | 1 | Output enable for the serial data output (low means high impedance) |
| rx_data_o | output | WORD_W | Last fully received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new received byte |
| tx_req_o | output | 1 | One-cycle request for the next output byte |
| tx_data_i | input | WORD_W | Next byte to shift out |
| tx_valid_i | input | 1 | Store `tx_data_i` as the next output byte |

## Verification
The bench builds the block with its default 8-bit word and a two-stage synchronizer. It runs the serial clock at 8 local cycles per half period. That leaves room for the synchronizer delay plus the output register before the master samples, so the half-period load window of the transmit path is exercised as a command layer would see it. With these values the bench reaches the following cases:
- both clock idle levels;
- a chip select held low through reset;
- an aborted three-bit fragment;
- a pause in the middle of a response byte with clock and data toggling;
- two bytes offered before a single load;
- a response byte that nobody supplied.

// File: rtl/spi_mem_front_pkg.sv
package spi_mem_front_pkg;

   // Bus pins as seen after synchronization.
   typedef struct packed {
      logic sck;
      logic cs_n;
      logic mosi;
      logic hold_n;
   } spi_pins_t;

   localparam int PIN_COUNT = $bits(spi_pins_t);

   // Reset image of the synchronizer: chip select reads as already low,
   // so a select held through reset never looks like a falling edge.
   localparam spi_pins_t PINS_RST = '{sck: 1'b0, cs_n: 1'b0, mosi: 1'b0, hold_n: 1'b1};

endpackage

// File: rtl/spi_sync_bank.sv
module spi_sync_bank #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("spi_sync_bank: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
         end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
         end
      end

      assign q_o = stg[STAGES-1];
   end

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
   parameter int WORD_W = 8,
   localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              rise_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] data_o,
   output logic              valid_o,
   output logic [CNT_W-1:0]  cnt_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-2:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         cnt_q   <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (!sel_i) begin
            cnt_q <= '0;
         end else if (rise_i) begin
            sh_q <= {sh_q[WORD_W-3:0], bit_i};
            if (cnt_q == LAST) begin
               cnt_q   <= '0;
               data_o  <= {sh_q, bit_i};
               valid_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
   parameter int                WORD_W = 8,
   parameter logic [WORD_W-1:0] FILL   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              active_i,
   input  logic              fall_i,
   input  logic              boundary_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic              valid_i,
   output logic              miso_o,
   output logic              oe_o
);

   logic [WORD_W-1:0] hold_q;
   logic              full_q;
   logic              pend_q;
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] src;

   assign src = full_q ? hold_q : FILL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
         pend_q <= 1'b0;
         sh_q   <= FILL;
         miso_o <= FILL[WORD_W-1];
         oe_o   <= 1'b0;
      end else begin
         oe_o <= active_i;
         if (!sel_i) begin
            full_q <= 1'b0;
            pend_q <= 1'b0;
            sh_q   <= FILL;
            miso_o <= FILL[WORD_W-1];
         end else begin
            if (fall_i) begin
               if (pend_q) begin
                  miso_o <= src[WORD_W-1];
                  sh_q   <= {src[WORD_W-2:0], 1'b1};
                  pend_q <= 1'b0;
               end else begin
                  miso_o <= sh_q[WORD_W-1];
                  sh_q   <= {sh_q[WORD_W-2:0], 1'b1};
               end
            end
            if (boundary_i) pend_q <= 1'b1;
            if (valid_i) begin
               hold_q <= data_i;
               full_q <= 1'b1;
            end else if (fall_i && pend_q) begin
               full_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
   import spi_mem_front_pkg::*;
#(
   parameter int                WORD_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [WORD_W-1:0] IDLE_FILL   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_i,
   input  logic              cs_n_i,
   input  logic              mosi_i,
   input  logic              hold_n_i,
   output logic              miso_o,
   output logic              miso_oe_o,
   output logic [WORD_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   output logic              tx_req_o,
   input  logic [WORD_W-1:0] tx_data_i,
   input  logic              tx_valid_i
);

   localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

   if (WORD_W < 2) begin : g_bad_word
      $error("spi_mem_front: WORD_W must be at least 2");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("spi_mem_front: SYNC_STAGES above 4 leaves no margin");
   end

   spi_pins_t pins_raw, pins_s;
   assign pins_raw = '{sck: sck_i, cs_n: cs_n_i, mosi: mosi_i, hold_n: hold_n_i};

   spi_sync_bank #(
      .WIDTH  (PIN_COUNT),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PINS_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pins_raw),
      .q_o  (pins_s)
   );

   logic sck_d, cs_n_d, armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d   <= PINS_RST.sck;
         cs_n_d  <= PINS_RST.cs_n;
         armed_q <= 1'b0;
      end else begin
         sck_d  <= pins_s.sck;
         cs_n_d <= pins_s.cs_n;
         if (cs_n_d && !pins_s.cs_n) armed_q <= 1'b1;
      end
   end

   logic sel, held, active, sck_rise, sck_fall;
   assign sel      = armed_q && !pins_s.cs_n;
   assign held     = sel && !pins_s.hold_n;
   assign active   = sel && !held;
   assign sck_rise = active && !sck_d && pins_s.sck;
   assign sck_fall = active && sck_d && !pins_s.sck;

   logic [CNT_W-1:0] rx_cnt;

   spi_rx_shift #(.WORD_W(WORD_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (sel),
      .rise_i (sck_rise),
      .bit_i  (pins_s.mosi),
      .data_o (rx_data_o),
      .valid_o(rx_valid_o),
      .cnt_o  (rx_cnt)
   );

   assign tx_req_o = rx_valid_o;

   spi_tx_shift #(.WORD_W(WORD_W), .FILL(IDLE_FILL)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel),
      .active_i  (active),
      .fall_i    (sck_fall),
      .boundary_i(rx_valid_o),
      .data_i    (tx_data_i),
      .valid_i   (tx_valid_i),
      .miso_o    (miso_o),
      .oe_o      (miso_oe_o)
   );

endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk #(
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel,
   input logic          held,
   input logic          armed_q,
   input logic          rx_valid_o,
   input logic          miso_oe_o,
   input logic [CW-1:0] rx_cnt
);

   // R4: deselection turns the output driver off one cycle later
   a_r4_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !miso_oe_o);

   // R5: nothing is reported or driven before the block is armed
   a_r5_silent_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> (!rx_valid_o && !miso_oe_o));

   // R1: received-byte strobe lasts one cycle
   a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   // R6: bit position returns to zero when deselected
   a_r6_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (rx_cnt == '0));

   // R7: bit position frozen during a pause
   a_r7_hold_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
      (held && $past(held)) |-> $stable(rx_cnt));

   // R7: output released during a pause
   a_r7_hold_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> !miso_oe_o);

endmodule

bind spi_mem_front spi_mem_front_chk #(.CW(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel       (sel),
   .held      (held),
   .armed_q   (armed_q),
   .rx_valid_o(rx_valid_o),
   .miso_oe_o (miso_oe_o),
   .rx_cnt    (rx_cnt)
);

// File: tb/spi_mem_front_bench.sv
module spi_mem_front_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic       clk, rst_n, sck, cs_n, mosi, hold_n;
   logic       miso_o, miso_oe_o, rx_valid_o, tx_req_o, tx_valid_i;
   logic [7:0] rx_data_o, tx_data_i;

   spi_mem_front u_spi_mem_front (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
      .hold_n_i(hold_n), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
      .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .tx_req_o(tx_req_o),
      .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int         n_vec = 0, n_bad = 0;
   logic [7:0] exp_rx_q[$];
   logic [7:0] prov_q[$];
   logic [7:0] push_q[$];
   bit         prov_en = 1'b0;
   bit         mode3   = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Command-layer model: direct pushes first, then answers to requests.
   initial begin
      tx_valid_i = 1'b0;
      tx_data_i  = '0;
      forever begin
         @(negedge clk);
         tx_valid_i = 1'b0;
         if (push_q.size() > 0) begin
            tx_data_i  = push_q.pop_front();
            tx_valid_i = 1'b1;
         end else if (prov_en && tx_req_o && prov_q.size() > 0) begin
            tx_data_i  = prov_q.pop_front();
            tx_valid_i = 1'b1;
         end
      end
   end

   // Monitor: received bytes against the scoreboard (R1, R8).
   always @(negedge clk) begin
      if (rst_n && rx_valid_o) begin
         if (exp_rx_q.size() == 0) begin
            check("R1 R5 unexpected byte", {24'd0, rx_data_o}, 32'hFFFF_FFFF);
         end else begin
            check("R1 received byte", {24'd0, rx_data_o}, {24'd0, exp_rx_q.pop_front()});
         end
         check("R8 request with byte", {31'd0, tx_req_o}, 32'd1);
      end
   end

   task automatic spi_bit(input logic b, output logic m, output logic oe);
      sck  = 1'b0;
      mosi = b;
      wait_clk(HALF);
      m  = miso_o;
      oe = miso_oe_o;
      sck = 1'b1;
      wait_clk(HALF);
   endtask

   task automatic spi_byte(input logic [7:0] v, output logic [7:0] m, output logic oe_all);
      oe_all = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         logic mb, ob;
         spi_bit(v[i], mb, ob);
         m[i]   = mb;
         oe_all = oe_all & ob;
      end
   endtask

   task automatic do_select();
      sck = mode3;
      wait_clk(HALF);
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic do_deselect();
      if (!mode3) begin
         sck = 1'b0;
         wait_clk(HALF);
      end
      cs_n = 1'b1;
      wait_clk(2*HALF);
   endtask

   task automatic run_all();
      logic [7:0] m;
      logic       oe, mb, ob;

      cs_n = 1'b0; sck = 1'b0; mosi = 1'b0; hold_n = 1'b1; rst_n = 1'b0;
      wait_clk(5);
      check("R4 reset oe", {31'd0, miso_oe_o}, 32'd0);
      check("R1 reset strobe", {31'd0, rx_valid_o}, 32'd0);
      rst_n = 1'b1;
      wait_clk(4);

      // R5: select held low through reset, traffic ignored
      spi_byte(8'hA5, m, oe);
      check("R5 oe while unarmed", {31'd0, oe}, 32'd0);
      do_deselect();

      // R2 / R9: clock idles low
      mode3 = 1'b0;
      prov_en = 1'b1;
      exp_rx_q.push_back(8'h03); exp_rx_q.push_back(8'h12);
      exp_rx_q.push_back(8'h34); exp_rx_q.push_back(8'h56);
      prov_q.push_back(8'h5A); prov_q.push_back(8'hC3);
      do_select();
      spi_byte(8'h03, m, oe);
      spi_byte(8'h12, m, oe);
      check("R2 first response byte", {24'd0, m}, 32'h5A);
      check("R4 oe while selected", {31'd0, oe}, 32'd1);
      spi_byte(8'h34, m, oe);
      check("R2 second response byte", {24'd0, m}, 32'hC3);
      spi_byte(8'h56, m, oe);
      check("R9 unsupplied byte", {24'd0, m}, 32'hFF);
      do_deselect();
      check("R4 oe after deselect", {31'd0, miso_oe_o}, 32'd0);

      // R3: clock idles high
      mode3 = 1'b1;
      exp_rx_q.push_back(8'h0B); exp_rx_q.push_back(8'hE7); exp_rx_q.push_back(8'h18);
      prov_q.push_back(8'h3C);
      do_select();
      spi_byte(8'h0B, m, oe);
      spi_byte(8'hE7, m, oe);
      check("R3 response with high idle", {24'd0, m}, 32'h3C);
      spi_byte(8'h18, m, oe);
      check("R3 R9 fill with high idle", {24'd0, m}, 32'hFF);
      do_deselect();
      mode3 = 1'b0;

      // R6: fragment aborted by deselect
      do_select();
      for (int i = 0; i < 3; i++) spi_bit(1'b1, mb, ob);
      do_deselect();
      exp_rx_q.push_back(8'h81);
      do_select();
      spi_byte(8'h81, m, oe);
      do_deselect();
      check("R6 no leftover byte", exp_rx_q.size(), 32'd0);

      // R8: latest offered byte wins
      prov_en = 1'b0;
      exp_rx_q.push_back(8'h02); exp_rx_q.push_back(8'h00);
      do_select();
      push_q.push_back(8'h11); push_q.push_back(8'h22);
      wait_clk(4);
      spi_byte(8'h02, m, oe);
      spi_byte(8'h00, m, oe);
      check("R8 latest byte used", {24'd0, m}, 32'h22);
      do_deselect();

      // R7: pause in the middle of a response byte
      prov_en = 1'b1;
      prov_q.push_back(8'h96);
      exp_rx_q.push_back(8'h0B); exp_rx_q.push_back(8'hB6);
      do_select();
      spi_byte(8'h0B, m, oe);
      for (int i = 7; i >= 4; i--) begin
         spi_bit(8'hB6 >> i, mb, ob);
         m[i] = mb;
      end
      hold_n = 1'b0;
      wait_clk(HALF);
      check("R7 oe during pause", {31'd0, miso_oe_o}, 32'd0);
      for (int i = 0; i < 3; i++) begin
         sck = 1'b0; mosi = ~mosi; wait_clk(HALF);
         sck = 1'b1; mosi = ~mosi; wait_clk(HALF);
      end
      hold_n = 1'b1;
      wait_clk(HALF);
      check("R7 oe after pause", {31'd0, miso_oe_o}, 32'd1);
      for (int i = 3; i >= 0; i--) begin
         spi_bit(8'hB6 >> i, mb, ob);
         m[i] = mb;
      end
      check("R7 response across pause", {24'd0, m}, 32'h96);
      do_deselect();

      wait_clk(10);
      check("R1 all bytes seen", exp_rx_q.size(), 32'd0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (200000) @(posedge clk);
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule